// File: doc/BRIEF.md
# Controller Power-Up Sequencer

This block steps a multiphase PWM controller from shutdown to the start of soft-start. It waits for the enable comparator and then for the supply power-on-reset flag. Next it runs a timed initialization interval and then a timed phase-detection window. During that window it samples the PWM pins to count the active phases. If either of the first two pins reads high, it latches off instead.

After detection it waits for the PLL lock flag, which is bounded by a timeout. It then holds the PWM outputs in a safe state for a fixed interval. After that it releases soft-start and enables the drivers. Power-good follows the output-in-window comparator while soft-start runs.

Losing enable or the POR flag in any state short of the latched fault sends the block back to shutdown. The latched fault is left only through reset. All interval lengths are cycle-count parameters. The defaults assume a 100 MHz clock: 80 µs for initialization, 30 µs for detection and 1 ms for the lock timeout.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, state_o is 0 (shutdown) and phase_cnt_o, drv_en_o, ss_start_o, pgood_o, fault_o, detect_o and clk_out_en_o are all 0.
- R2: From shutdown (0), en_ok_i high moves to state 1 (wait for supply) on the next clock. From state 1, por_ok_i high with en_ok_i high moves to state 2 (initialization) on the next clock.
- R3: State 2 lasts exactly INIT_CYC clocks and is then followed by state 3 (detection).
- R4: State 3 lasts exactly DET_CYC clocks when no fault is found, and is then followed by state 4 (PLL wait). detect_o is high only in state 3.
- R5: pin_high_i[0] is the first PWM pin, and a high pin means the pin is disabled. At the end of detection, phase_cnt_o takes the count of consecutive low pins starting at index 0. The value is held until the next detection ends.
- R6: If pin_high_i[0] or pin_high_i[1] is high in state 3, the next state is 7 (fault). In state 7, fault_o is high and drv_en_o is low, and the block stays in state 7 whatever en_ok_i and por_ok_i do, until rst_ni is asserted.
- R7: In state 4, pll_lock_i high moves to state 5 (safe hold) on the next clock. Lock seen in the LOCK_TO_CYC-th clock of state 4 is still accepted. If lock is not seen within LOCK_TO_CYC clocks, the next state is 7.
- R8: clk_out_en_o is high only in states 5 and 6.
- R9: hold_mode_o is 2'b00 (outputs run) in state 6. In every other state it is 2'b10 (high impedance) when tri_sel_i is 1 and 2'b01 (driven low) when tri_sel_i is 0. drv_en_o is high only in state 6.
- R10: State 5 lasts exactly HOLD_CYC clocks and is then followed by state 6 (soft-start). ss_start_o is high only in state 6.
- R11: pgood_o is out_in_win_i registered on the clock edge, valid while the block is (or is entering) state 6. pgood_o is 0 in every other state.
- R12: In states 2 to 6, en_ok_i low or por_ok_i low gives state 0 on the next clock. In state 1, en_ok_i low does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_ok_i | input | 1 | Enable voltage above threshold |
| por_ok_i | input | 1 | Supply above power-on-reset rising threshold |
| pin_high_i | input | NPH | Per-phase PWM pin sampled high (disabled) |
| pll_lock_i | input | 1 | PLL lock indication |
| tri_sel_i | input | 1 | Tri-level PWM output selected |
| out_in_win_i | input | 1 | Output voltage inside regulation window |
| state_o | output | 3 | Sequencer state code |
| phase_cnt_o | output | $clog2(NPH+1) | Detected active phase count |
| hold_mode_o | output | 2 | PWM output mode: 00 run, 01 low, 10 high impedance |
| detect_o | output | 1 | Phase-detection window active |
| clk_out_en_o | output | 1 | Clock output enable |
| drv_en_o | output | 1 | External driver enable |
| ss_start_o | output | 1 | Soft-start released |
| pgood_o | output | 1 | Power-good |
| fault_o | output | 1 | Latched fault |

## Verification
Every state change appears on state_o one clock after the input that causes it, because the state register is the only stage. The bench drives inputs and samples outputs on the falling edge. It counts how many falling edges each timed state shows, and compares that count with the exact interval parameter.

phase_cnt_o is due on the first sample of state 4, and pgood_o on the sample after out_in_win_i is raised. A loss of enable or POR must show as state 0 on the very next sample. A fault must show as state 7 on the sample after the first detection sample. The lock boundary is checked both ways: lock in the last allowed clock, and lock one clock too late.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_WAIT_POR = 3'd1,
    ST_INIT     = 3'd2,
    ST_DETECT   = 3'd3,
    ST_PLL_WAIT = 3'd4,
    ST_HOLD     = 3'd5,
    ST_SOFT     = 3'd6,
    ST_FAULT    = 3'd7
  } seq_state_e;

  typedef enum logic [1:0] {
    HM_RUN = 2'b00,
    HM_LOW = 2'b01,
    HM_HIZ = 2'b10
  } hold_mode_e;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] limit_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + TW'(1);
  end

  // last cycle of the interval
  assign done_o = (cnt_q == limit_i - TW'(1));
endmodule

// File: rtl/pwr_seq_phase_det.sv
module pwr_seq_phase_det #(
  parameter int NPH = 4,
  parameter int CW  = $clog2(NPH + 1)
) (
  input  logic [NPH-1:0] pin_high_i,
  output logic           bad_o,
  output logic [CW-1:0]  cnt_o
);
  logic [NPH-1:0] run;

  assign run[0] = ~pin_high_i[0];
  for (genvar i = 1; i < NPH; i++) begin : g_run
    assign run[i] = run[i-1] & ~pin_high_i[i];
  end

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NPH; i++) cnt_o = cnt_o + CW'(run[i]);
  end

  // first two phases are mandatory
  assign bad_o = pin_high_i[0] | pin_high_i[1];
endmodule

// File: rtl/pwr_seq_out_dec.sv
module pwr_seq_out_dec
  import pwr_seq_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       tri_sel_i,
  output hold_mode_e hold_mode_o,
  output logic       detect_o,
  output logic       clk_out_en_o,
  output logic       drv_en_o,
  output logic       ss_start_o,
  output logic       fault_o
);
  always_comb begin
    hold_mode_o  = tri_sel_i ? HM_HIZ : HM_LOW;
    detect_o     = 1'b0;
    clk_out_en_o = 1'b0;
    drv_en_o     = 1'b0;
    ss_start_o   = 1'b0;
    fault_o      = 1'b0;
    unique case (state_i)
      ST_DETECT: detect_o = 1'b1;
      ST_HOLD:   clk_out_en_o = 1'b1;
      ST_SOFT: begin
        hold_mode_o  = HM_RUN;
        clk_out_en_o = 1'b1;
        drv_en_o     = 1'b1;
        ss_start_o   = 1'b1;
      end
      ST_FAULT:  fault_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NPH        = 4,
  parameter int INIT_CYC   = 8000,
  parameter int DET_CYC    = 3000,
  parameter int LOCK_TO_CYC = 100000,
  parameter int HOLD_CYC   = 64,
  parameter int CW         = $clog2(NPH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_ok_i,
  input  logic           por_ok_i,
  input  logic [NPH-1:0] pin_high_i,
  input  logic           pll_lock_i,
  input  logic           tri_sel_i,
  input  logic           out_in_win_i,
  output logic [2:0]     state_o,
  output logic [CW-1:0]  phase_cnt_o,
  output logic [1:0]     hold_mode_o,
  output logic           detect_o,
  output logic           clk_out_en_o,
  output logic           drv_en_o,
  output logic           ss_start_o,
  output logic           pgood_o,
  output logic           fault_o
);
  localparam int MAX_A = (INIT_CYC > DET_CYC) ? INIT_CYC : DET_CYC;
  localparam int MAX_B = (LOCK_TO_CYC > HOLD_CYC) ? LOCK_TO_CYC : HOLD_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAXC + 1);
  localparam logic [TW-1:0] INIT_L = TW'(INIT_CYC);
  localparam logic [TW-1:0] DET_L  = TW'(DET_CYC);
  localparam logic [TW-1:0] LOCK_L = TW'(LOCK_TO_CYC);
  localparam logic [TW-1:0] HOLD_L = TW'(HOLD_CYC);

  seq_state_e    state_q, state_d;
  logic [TW-1:0] limit;
  logic          tmr_done, tmr_clr;
  logic          pin_bad;
  logic [CW-1:0] ph_cnt, phase_q;
  logic          pgood_q;
  hold_mode_e    hmode;

  pwr_seq_timer #(.TW(TW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .limit_i (limit),
    .done_o  (tmr_done)
  );

  pwr_seq_phase_det #(.NPH(NPH), .CW(CW)) u_det (
    .pin_high_i (pin_high_i),
    .bad_o      (pin_bad),
    .cnt_o      (ph_cnt)
  );

  pwr_seq_out_dec u_dec (
    .state_i      (state_q),
    .tri_sel_i    (tri_sel_i),
    .hold_mode_o  (hmode),
    .detect_o     (detect_o),
    .clk_out_en_o (clk_out_en_o),
    .drv_en_o     (drv_en_o),
    .ss_start_o   (ss_start_o),
    .fault_o      (fault_o)
  );

  always_comb begin
    unique case (state_q)
      ST_INIT:     limit = INIT_L;
      ST_DETECT:   limit = DET_L;
      ST_PLL_WAIT: limit = LOCK_L;
      ST_HOLD:     limit = HOLD_L;
      default:     limit = '1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:      if (en_ok_i) state_d = ST_WAIT_POR;
      ST_WAIT_POR: begin
        if (!en_ok_i)      state_d = ST_OFF;
        else if (por_ok_i) state_d = ST_INIT;
      end
      ST_FAULT:    state_d = ST_FAULT;
      default: begin
        if (!en_ok_i || !por_ok_i) begin
          state_d = ST_OFF;
        end else begin
          unique case (state_q)
            ST_INIT:     if (tmr_done) state_d = ST_DETECT;
            ST_DETECT: begin
              if (pin_bad)       state_d = ST_FAULT;
              else if (tmr_done) state_d = ST_PLL_WAIT;
            end
            ST_PLL_WAIT: begin
              if (pll_lock_i)    state_d = ST_HOLD;
              else if (tmr_done) state_d = ST_FAULT;
            end
            ST_HOLD:     if (tmr_done) state_d = ST_SOFT;
            default: ;
          endcase
        end
      end
    endcase
  end

  assign tmr_clr = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      phase_q <= '0;
      pgood_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DETECT && state_d == ST_PLL_WAIT) phase_q <= ph_cnt;
      pgood_q <= (state_d == ST_SOFT) && out_in_win_i;
    end
  end

  assign state_o     = state_q;
  assign phase_cnt_o = phase_q;
  assign hold_mode_o = hmode;
  assign pgood_o     = pgood_q;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int CW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_ok_i,
  input logic          por_ok_i,
  input logic          pll_lock_i,
  input logic [2:0]    state_o,
  input logic [CW-1:0] phase_cnt_o,
  input logic          detect_o,
  input logic          clk_out_en_o,
  input logic          drv_en_o,
  input logic          ss_start_o,
  input logic          pgood_o,
  input logic          fault_o
);
  a_r6_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd7 |=> state_o == 3'd7);

  a_r6_fault_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !drv_en_o && !clk_out_en_o);

  a_r12_drop_to_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd6}) && (!en_ok_i || !por_ok_i)
      |=> state_o == 3'd0);

  a_r7_lock_to_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd4 && pll_lock_i && en_ok_i && por_ok_i |=> state_o == 3'd5);

  a_r5_phase_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 3'd3 |=> $stable(phase_cnt_o));

  a_r11_pgood_in_soft: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o |-> ss_start_o);

  a_r10_soft_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_start_o) |-> $past(state_o) == 3'd5);

  a_r4_detect_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(detect_o) |-> state_o inside {3'd0, 3'd4, 3'd7});
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_ok_i      (en_ok_i),
  .por_ok_i     (por_ok_i),
  .pll_lock_i   (pll_lock_i),
  .state_o      (state_o),
  .phase_cnt_o  (phase_cnt_o),
  .detect_o     (detect_o),
  .clk_out_en_o (clk_out_en_o),
  .drv_en_o     (drv_en_o),
  .ss_start_o   (ss_start_o),
  .pgood_o      (pgood_o),
  .fault_o      (fault_o)
);

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  localparam int NPH = 4;
  localparam int INIT_CYC = 20;
  localparam int DET_CYC = 12;
  localparam int LOCK_TO_CYC = 40;
  localparam int HOLD_CYC = 6;
  localparam int CW = $clog2(NPH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_ok_i = 1'b0, por_ok_i = 1'b0, pll_lock_i = 1'b0;
  logic tri_sel_i = 1'b0, out_in_win_i = 1'b0;
  logic [NPH-1:0] pin_high_i = '0;
  logic [2:0] state_o;
  logic [CW-1:0] phase_cnt_o;
  logic [1:0] hold_mode_o;
  logic detect_o, clk_out_en_o, drv_en_o, ss_start_o, pgood_o, fault_o;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  pwr_seq_ctrl #(
    .NPH(NPH), .INIT_CYC(INIT_CYC), .DET_CYC(DET_CYC),
    .LOCK_TO_CYC(LOCK_TO_CYC), .HOLD_CYC(HOLD_CYC)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_ok_i(en_ok_i), .por_ok_i(por_ok_i),
    .pin_high_i(pin_high_i), .pll_lock_i(pll_lock_i), .tri_sel_i(tri_sel_i),
    .out_in_win_i(out_in_win_i), .state_o(state_o), .phase_cnt_o(phase_cnt_o),
    .hold_mode_o(hold_mode_o), .detect_o(detect_o), .clk_out_en_o(clk_out_en_o),
    .drv_en_o(drv_en_o), .ss_start_o(ss_start_o), .pgood_o(pgood_o),
    .fault_o(fault_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_phases(input logic [NPH-1:0] p);
    int n = 0;
    for (int i = 0; i < NPH; i++) begin
      if (p[i]) break;
      n++;
    end
    return n;
  endfunction

  function automatic int exp_hold(input logic t);
    return t ? 2 : 1;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic count_state(input int s, output int n);
    n = 0;
    while (state_o == 3'(s) && n < 5000) begin
      n++;
      step();
    end
  endtask

  task automatic do_reset(input logic t);
    en_ok_i = 0; por_ok_i = 0; pll_lock_i = 0; out_in_win_i = 0;
    tri_sel_i = t;
    rst_ni = 0;
    repeat (2) step();
    rst_ni = 1;
    step();
    chk("R1 state", state_o, 0);
    chk("R1 outputs", {phase_cnt_o, drv_en_o, ss_start_o, pgood_o, fault_o,
                       detect_o, clk_out_en_o}, 0);
    chk("R9 hold reset", hold_mode_o, exp_hold(t));
  endtask

  task automatic run_full(input logic [NPH-1:0] pins, input logic t, input int dly);
    int n;
    do_reset(t);
    pin_high_i = pins;
    en_ok_i = 1; step();
    chk("R2 wait_por", state_o, 1);
    por_ok_i = 1; step();
    chk("R2 init", state_o, 2);
    count_state(2, n);
    chk("R3 init length", n, INIT_CYC);
    chk("R3 detect next", state_o, 3);
    chk("R4 detect flag", detect_o, 1);
    count_state(3, n);
    if (pins[0] || pins[1]) begin
      chk("R6 fault detect len", n, 1);
      chk("R6 fault state", state_o, 7);
      chk("R6 fault out", {fault_o, drv_en_o}, 2'b10);
      en_ok_i = 0; por_ok_i = 0;
      repeat (3) step();
      chk("R6 fault sticky", {state_o, fault_o}, {3'd7, 1'b1});
      return;
    end
    chk("R4 detect length", n, DET_CYC);
    chk("R4 pll next", {state_o, detect_o}, {3'd4, 1'b0});
    chk("R5 phase count", phase_cnt_o, exp_phases(pins));
    chk("R8 no clk in pll wait", clk_out_en_o, 0);
    n = 0;
    while (state_o == 3'd4 && n < 5000) begin
      n++;
      if (n == dly) pll_lock_i = 1;
      step();
    end
    if (dly > LOCK_TO_CYC) begin
      chk("R7 timeout len", n, LOCK_TO_CYC);
      chk("R7 timeout fault", {state_o, fault_o}, {3'd7, 1'b1});
      return;
    end
    chk("R7 lock len", n, dly);
    chk("R7 hold state", state_o, 5);
    chk("R8 clk in hold", clk_out_en_o, 1);
    chk("R9 hold mode", hold_mode_o, exp_hold(t));
    chk("R9 drv off in hold", drv_en_o, 0);
    count_state(5, n);
    chk("R10 hold length", n, HOLD_CYC);
    chk("R10 soft state", {state_o, ss_start_o}, {3'd6, 1'b1});
    chk("R9 run mode", {hold_mode_o, drv_en_o}, {2'b00, 1'b1});
    chk("R11 pgood low", pgood_o, 0);
    out_in_win_i = 1; step();
    chk("R11 pgood high", pgood_o, 1);
    out_in_win_i = 0; step();
    chk("R11 pgood follows", pgood_o, 0);
    out_in_win_i = 1; step();
    if ($urandom % 2) en_ok_i = 0; else por_ok_i = 0;
    step();
    chk("R12 drop from soft", {state_o, pgood_o, ss_start_o}, 0);
    out_in_win_i = 0;
  endtask

  task automatic drop_run(input int target, input logic use_por);
    int n = 0;
    do_reset(1'b0);
    pin_high_i = '0;
    pll_lock_i = 1;
    en_ok_i = 1;
    if (target != 1) por_ok_i = 1;
    while (state_o != 3'(target) && n < 500) begin n++; step(); end
    repeat ($urandom % 2) if (state_o == 3'(target)) step();
    if (use_por && target != 1) por_ok_i = 0; else en_ok_i = 0;
    step();
    chk($sformatf("R12 drop from %0d", target), state_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // directed corners
    run_full(4'b0000, 1'b0, 3);
    run_full(4'b0100, 1'b1, 1);
    run_full(4'b1000, 1'b0, 5);
    run_full(4'b0001, 1'b1, 2);
    run_full(4'b0010, 1'b0, 2);
    run_full(4'b0000, 1'b1, LOCK_TO_CYC);
    run_full(4'b0000, 1'b0, LOCK_TO_CYC + 1);
    for (int k = 0; k < 25; k++) begin
      logic [NPH-1:0] p = NPH'($urandom);
      if ($urandom % 4 != 0) p[1:0] = 2'b00;
      run_full(p, 1'($urandom), 1 + int'($urandom % (LOCK_TO_CYC + 8)));
    end
    for (int s = 1; s <= 6; s++) begin
      drop_run(s, 1'b0);
      drop_run(s, 1'b1);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule